// File: doc/BRIEF.md
# Write-Hit Test Counter Peripheral

This peripheral gives a host a simple way to test its bus path. It has two address windows, a memory window and an I/O window, and every access is one byte wide. A write to address 0 picks one of six test slots. The slot is chosen by the window that carried the write and by the value written. The chosen slot then counts the writes that land on its trigger address. The host can read the slot's header byte by byte. The header describes the test and holds the running count.

The three test kinds differ in how they filter writes and whether they signal an event. Kind 0 (quiet) and kind 2 (exact) count a write only when its size is one byte and its value is 0xFA. Kind 1 (wildcard) counts every write to the trigger address. Kinds 1 and 2 also raise a one-cycle event pulse and set a sticky event flag for each counted write.

Control is a two-state machine:
- `ST_IDLE` means no slot is active.
- `ST_ACTIVE` means one slot is active.

Its transitions are:
- `T_ARM` goes from `ST_IDLE` to `ST_ACTIVE` on a valid select.
- `T_REARM` goes from `ST_ACTIVE` to `ST_ACTIVE` on a valid select, which switches the slot and clears the count.
- `T_DISARM` goes from `ST_ACTIVE` to `ST_IDLE` on a select whose value is 3 or more.
- `T_RESET` returns to `ST_IDLE` from either state on reset.

Top module: `wr_hit_probe`

## Requirements
- R1: After reset no slot is active. `rd_valid`, `rd_data`, `evt_pulse` and `evt_flag` are all 0, and a read of any address returns 0.
- R2: A write to address 0 with a value v below 3 activates slot w*3+v, where w is `req_win` (0 = memory, 1 = I/O). It also clears the slot's 32-bit count to 0. Header byte 0 then reads back the slot index.
- R3: A write to address 0 with a value of 3 or more (compared over all 32 data bits) leaves no slot active. While no slot is active, reads return 0 and writes to other addresses change nothing.
- R4: The header bytes are fixed as follows:
  - byte 1 reads 1 (the access width);
  - bytes 2, 3, 9, 10 and 11 read 0;
  - bytes 4..7 hold the trigger address, little-endian, equal to 2048+slot for memory slots and 128+slot for I/O slots;
  - byte 8 reads 0xCE for kind 1 and 0xFA for kinds 0 and 2.
- R5: Starting at byte 16, the header holds the ASCII name. The name is "mmio" or "portio", then "-", then "no-eventfd", "wildcard-eventfd" or "datamatch-eventfd" by kind. A zero byte follows the name.
- R6: A read at address A with size S returns 0 when A+S is greater than or equal to the header length. The header length is 17 plus the name length.
- R7: A write to the active slot's trigger address increments the count, held little-endian in bytes 12..15, by 1, when it passes the filter. Kind 1 counts any such write regardless of value or size. The comparison uses the address alone, whichever window carries the write.
- R8: Kinds 0 and 2 count a trigger write only when its size is 1 and its 32-bit value is 0xFA.
- R9: Writes to any address other than 0 and the active trigger address leave the count unchanged.
- R10: A counted write on a kind 1 or kind 2 slot raises `evt_pulse` for exactly the cycle after the write. Kind 0 never raises it.
- R11: `evt_flag` sets with each event pulse. It clears on any write to address 0, on reset, and on an in-range read while a slot is active.
- R12: Every read request gives `rd_valid` high in the next cycle, with `rd_data` valid in that cycle. Writes never give `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | Window of the access: 0 memory, 1 I/O |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write value |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 8 | Read data byte |
| evt_pulse | output | 1 | One-cycle event on a counted write (kinds 1 and 2) |
| evt_flag | output | 1 | Sticky event flag |

## Verification
The bench goes after three boundaries.

The first is the last readable header byte. The design must return 0 once A+S reaches the header length. A design that compared with > instead of >= would leak the terminating zero or read past the name.

The second is the data-match filter. It must count a one-byte write of 0xFA and reject a two-byte write of 0xFA and a one-byte write of 0xFB. A filter that ignored size, or that compared only the low data byte, would count writes it should reject.

The third is the kind 0 slot, which must count without pulsing. A design that keyed the event on the filter rather than the kind would pulse there.

Selects with large 32-bit values, writes while idle, and reselects that must zero the count are mixed into long random runs. A design that truncated the select compare, or kept the count across a rearm, would show a wrong header byte on a later read.

// File: rtl/whp_pkg.sv
package whp_pkg;

    localparam int KINDS      = 3;
    localparam int WINDOWS    = 2;
    localparam int SLOTS      = KINDS * WINDOWS;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int KIND_W     = $clog2(KINDS);
    localparam int HDR_FIXED  = 16;
    localparam int ACC_BYTES  = 1;
    localparam int KIND_QUIET = 0;
    localparam int KIND_WILD  = 1;

    localparam logic [7:0] WILD_BYTE  = 8'hCE;
    localparam logic [7:0] MATCH_BYTE = 8'hFA;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } whp_state_e;

    localparam logic [47:0]  WIN0_STR  = {16'h0000, "mmio"};
    localparam logic [47:0]  WIN1_STR  = "portio";
    localparam logic [135:0] KIND0_STR = {56'h0, "no-eventfd"};
    localparam logic [135:0] KIND1_STR = {8'h00, "wildcard-eventfd"};
    localparam logic [135:0] KIND2_STR = "datamatch-eventfd";

    function automatic int win_len(int w);
        return (w == 0) ? 4 : 6;
    endfunction

    function automatic int kind_len(int k);
        case (k)
            0:       return 10;
            1:       return 16;
            default: return 17;
        endcase
    endfunction

    function automatic int name_len(int s);
        return win_len(s / KINDS) + 1 + kind_len(s % KINDS);
    endfunction

    // Character i of the name of slot s; 0 past its end.
    function automatic logic [7:0] name_char(int s, int i);
        int wl = win_len(s / KINDS);
        int kl = kind_len(s % KINDS);
        int j;
        logic [47:0]  ws;
        logic [135:0] ks;
        ws = ((s / KINDS) == 0) ? WIN0_STR : WIN1_STR;
        case (s % KINDS)
            0:       ks = KIND0_STR;
            1:       ks = KIND1_STR;
            default: ks = KIND2_STR;
        endcase
        if (i < 0)   return 8'h00;
        if (i < wl)  return ws[8*(wl-1-i) +: 8];
        if (i == wl) return 8'h2D;
        j = i - wl - 1;
        if (j < kl)  return ks[8*(kl-1-j) +: 8];
        return 8'h00;
    endfunction

endpackage

// File: rtl/whp_header.sv
module whp_header
    import whp_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int SIZE_W   = 4,
    parameter int CNT_W    = 32,
    parameter int MEM_BASE = 2048,
    parameter int IO_BASE  = 128
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [7:0]        byte_o,
    output logic              in_range_o,
    output logic [ADDR_W-1:0] trig_o
);

    localparam int TBL = 2 ** SLOT_W;

    logic [7:0]        len_tbl  [TBL];
    logic [ADDR_W-1:0] trig_tbl [TBL];
    logic [31:0]       trig32;
    logic [31:0]       cnt32;
    logic [ADDR_W:0]   end_addr;
    logic [KIND_W-1:0] kind;

    // Per-slot header length and trigger address, fixed at elaboration.
    for (genvar s = 0; s < TBL; s++) begin : g_slot
        if (s < SLOTS) begin : g_real
            assign len_tbl[s]  = 8'(HDR_FIXED + name_len(s) + 1);
            assign trig_tbl[s] = ADDR_W'((((s / KINDS) == 0) ? MEM_BASE : IO_BASE) + s);
        end else begin : g_none
            assign len_tbl[s]  = 8'd0;
            assign trig_tbl[s] = '0;
        end
    end

    assign trig_o     = trig_tbl[slot_i];
    assign trig32     = 32'(trig_o);
    assign cnt32      = 32'(count_i);
    assign kind       = KIND_W'(int'(slot_i) % KINDS);
    assign end_addr   = {1'b0, addr_i} + (ADDR_W + 1)'(size_i);
    assign in_range_o = end_addr < (ADDR_W + 1)'(len_tbl[slot_i]);

    always_comb begin
        byte_o = 8'h00;
        if (addr_i < ADDR_W'(HDR_FIXED)) begin
            unique case (addr_i[3:0])
                4'd0:    byte_o = 8'(slot_i);
                4'd1:    byte_o = 8'(ACC_BYTES);
                4'd4:    byte_o = trig32[7:0];
                4'd5:    byte_o = trig32[15:8];
                4'd6:    byte_o = trig32[23:16];
                4'd7:    byte_o = trig32[31:24];
                4'd8:    byte_o = (kind == KIND_W'(KIND_WILD)) ? WILD_BYTE : MATCH_BYTE;
                4'd12:   byte_o = cnt32[7:0];
                4'd13:   byte_o = cnt32[15:8];
                4'd14:   byte_o = cnt32[23:16];
                4'd15:   byte_o = cnt32[31:24];
                default: byte_o = 8'h00;
            endcase
        end else begin
            byte_o = name_char(int'(slot_i), int'(addr_i) - HDR_FIXED);
        end
    end

endmodule

// File: rtl/whp_filter.sv
module whp_filter
    import whp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 4
) (
    input  logic [KIND_W-1:0] kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] trig_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              hit_o
);

    logic addr_hit;
    logic data_ok;

    assign addr_hit = (addr_i == trig_i);
    assign data_ok  = (kind_i == KIND_W'(KIND_WILD)) ||
                      ((size_i == SIZE_W'(ACC_BYTES)) && (wdata_i == DATA_W'(MATCH_BYTE)));
    assign hit_o    = addr_hit && data_ok;

endmodule

// File: rtl/whp_counter.sv
module whp_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/wr_hit_probe.sv
module wr_hit_probe
    import whp_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int SIZE_W   = 4,
    parameter int CNT_W    = 32,
    parameter int MEM_BASE = 2048,
    parameter int IO_BASE  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_win,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              evt_pulse,
    output logic              evt_flag
);

    whp_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, sel_slot;
    logic [KIND_W-1:0] kind_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] trig;
    logic [7:0]        hdr_byte;
    logic              in_range;
    logic              sel_wr, sel_ok, active, data_wr, filt_hit, hit, rd_req, evt_hit;

    assign sel_wr   = req_valid && req_write && (req_addr == '0);
    assign sel_ok   = sel_wr && (req_wdata < DATA_W'(KINDS));
    assign sel_slot = (req_win ? SLOT_W'(KINDS) : SLOT_W'(0)) + SLOT_W'(req_wdata[KIND_W-1:0]);
    assign active   = (state_q == ST_ACTIVE);
    assign data_wr  = req_valid && req_write && (req_addr != '0) && active;
    assign hit      = data_wr && filt_hit;
    assign evt_hit  = hit && (kind_q != KIND_W'(KIND_QUIET));
    assign rd_req   = req_valid && !req_write;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sel_ok)            state_d = ST_ACTIVE;  // T_ARM
            ST_ACTIVE: if (sel_wr && !sel_ok) state_d = ST_IDLE;    // T_DISARM; T_REARM stays
            default:                          state_d = ST_IDLE;
        endcase
    end

    // State register with the active slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;  // T_RESET
            slot_q  <= '0;
            kind_q  <= '0;
        end else begin
            state_q <= state_d;
            if (sel_ok) begin
                slot_q <= sel_slot;
                kind_q <= req_wdata[KIND_W-1:0];
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= 8'h00;
            evt_pulse <= 1'b0;
            evt_flag  <= 1'b0;
        end else begin
            rd_valid  <= rd_req;
            rd_data   <= (rd_req && active && in_range) ? hdr_byte : 8'h00;
            evt_pulse <= evt_hit;
            if (sel_wr) begin
                evt_flag <= 1'b0;
            end else if (evt_hit) begin
                evt_flag <= 1'b1;
            end else if (rd_req && active && in_range) begin
                evt_flag <= 1'b0;
            end
        end
    end

    whp_header #(
        .ADDR_W  (ADDR_W),
        .SIZE_W  (SIZE_W),
        .CNT_W   (CNT_W),
        .MEM_BASE(MEM_BASE),
        .IO_BASE (IO_BASE)
    ) u_header (
        .slot_i    (slot_q),
        .addr_i    (req_addr),
        .size_i    (req_size),
        .count_i   (cnt_q),
        .byte_o    (hdr_byte),
        .in_range_o(in_range),
        .trig_o    (trig)
    );

    whp_filter #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SIZE_W(SIZE_W)
    ) u_filter (
        .kind_i (kind_q),
        .addr_i (req_addr),
        .trig_i (trig),
        .size_i (req_size),
        .wdata_i(req_wdata),
        .hit_o  (filt_hit)
    );

    whp_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(sel_ok),
        .inc_i(hit),
        .cnt_o(cnt_q)
    );

endmodule

// File: rtl/whp_checker.sv
module whp_checker
    import whp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rd_valid,
    input logic [7:0]        rd_data,
    input logic              evt_pulse,
    input logic              evt_flag,
    input whp_state_e        state_q,
    input logic [KIND_W-1:0] kind_q,
    input logic [CNT_W-1:0]  cnt_q
);

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);  // R12

    AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));  // R12

    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ($past(state_q) == ST_IDLE)) |-> (rd_data == 8'h00));  // R3

    AST_SELECT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && (req_addr == '0) && (req_wdata < DATA_W'(KINDS)))
        |-> (cnt_q == '0));  // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));  // R7

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> evt_flag);  // R11

    AST_QUIET_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> ($past(kind_q) != KIND_W'(KIND_QUIET)));  // R10

endmodule

bind wr_hit_probe whp_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_whp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .evt_pulse(evt_pulse),
    .evt_flag (evt_flag),
    .state_q  (state_q),
    .kind_q   (kind_q),
    .cnt_q    (cnt_q)
);

// File: tb/tb_wr_hit_probe.sv
module tb_wr_hit_probe;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_win = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_size = 4'd1;
    logic [31:0]       req_wdata = '0;
    logic              rd_valid;
    logic [7:0]        rd_data;
    logic              evt_pulse;
    logic              evt_flag;

    int checks = 0;
    int errors = 0;

    bit          m_active = 0;
    int          m_slot   = 0;
    logic [31:0] m_cnt    = 0;
    bit          m_flag   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wr_hit_probe dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_win(req_win), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .evt_pulse(evt_pulse), .evt_flag(evt_flag)
    );

    function automatic string exp_name(int s);
        string w = (s / 3 == 0) ? "mmio" : "portio";
        string k;
        case (s % 3)
            0:       k = "no-eventfd";
            1:       k = "wildcard-eventfd";
            default: k = "datamatch-eventfd";
        endcase
        return {w, "-", k};
    endfunction

    function automatic int exp_len(int s);
        return 17 + exp_name(s).len();
    endfunction

    function automatic int exp_off(int s);
        return ((s < 3) ? 2048 : 128) + s;
    endfunction

    function automatic logic [7:0] exp_byte(int a, int sz);
        string nm;
        int s = m_slot;
        logic [31:0] off = 32'(exp_off(s));
        if (!m_active) return 8'h00;
        if (a + sz >= exp_len(s)) return 8'h00;
        if (a >= 16) begin
            nm = exp_name(s);
            return (a - 16 < nm.len()) ? nm[a-16] : 8'h00;
        end
        case (a)
            0:              return 8'(s);
            1:              return 8'd1;
            4, 5, 6, 7:     return off[8*(a-4) +: 8];
            8:              return (s % 3 == 1) ? 8'hCE : 8'hFA;
            12, 13, 14, 15: return m_cnt[8*(a-12) +: 8];
            default:        return 8'h00;
        endcase
    endfunction

    function automatic string auto_tag(int a, int sz);
        if (!m_active) return "R3";
        if (a + sz >= exp_len(m_slot)) return "R6";
        if (a >= 16) return "R5";
        if (a >= 12) return "R7";
        if (a == 0) return "R2";
        return "R4";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic op(input bit wr, input bit win, input int addr, input int sz,
                      input logic [31:0] data, input string tag);
        logic [7:0] e_rd = 8'h00;
        bit e_pulse = 0;
        string t = tag;
        if (!wr) begin
            e_rd = exp_byte(addr, sz);
            if (t == "") t = auto_tag(addr, sz);
            if (m_active && (addr + sz < exp_len(m_slot))) m_flag = 0;
        end else if (addr == 0) begin
            m_flag = 0;
            if (data < 3) begin
                m_active = 1;
                m_slot   = (win ? 3 : 0) + int'(data);
                m_cnt    = 0;
            end else begin
                m_active = 0;
            end
        end else if (m_active && addr == exp_off(m_slot) &&
                     (m_slot % 3 == 1 || (sz == 1 && data == 32'hFA))) begin
            m_cnt = m_cnt + 1;
            if (m_slot % 3 != 0) begin
                e_pulse = 1;
                m_flag  = 1;
            end
        end
        req_valid = 1'b1;
        req_write = wr;
        req_win   = win;
        req_addr  = ADDR_W'(addr);
        req_size  = 4'(sz);
        req_wdata = data;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        if (!wr) begin
            chk("R12", 32'(rd_valid), 32'd1);
            chk(t, 32'(rd_data), 32'(e_rd));
        end else begin
            chk("R12", 32'(rd_valid), 32'd0);
        end
        chk("R10", 32'(evt_pulse), 32'(e_pulse));
        chk("R11", 32'(evt_flag), 32'(m_flag));
    endtask

    task automatic rd_cnt(input string tag);
        for (int a = 12; a < 16; a++) op(0, 0, a, 1, 0, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_active = 0; m_flag = 0; m_cnt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        do_reset();
        // R1 reset state
        chk("R1", 32'(rd_valid), 0);
        chk("R1", 32'(rd_data), 0);
        chk("R1", 32'(evt_pulse), 0);
        chk("R1", 32'(evt_flag), 0);
        op(0, 0, 0, 1, 0, "R1");
        op(0, 1, 16, 1, 0, "R1");

        // R2 R4 R5 R6: full header dump of every slot
        for (int s = 0; s < 6; s++) begin
            op(1, s >= 3, 0, 1, 32'(s % 3), "");
            for (int a = 0; a < exp_len(s) + 1; a++) op(0, 0, a, 1, 0, "");
            op(0, 0, exp_len(s) - 2, 1, 0, "R6");
            op(0, 0, exp_len(s) - 3, 2, 0, "R6");
            op(0, 0, exp_len(s) - 2, 2, 0, "R6");
        end

        // R7 wildcard slot (memory, kind 1) counts any value and size
        op(1, 0, 0, 1, 1, "");
        op(1, 0, exp_off(1), 1, 32'h12, "R7");
        op(1, 1, exp_off(1), 2, 32'hFFFF, "R7");
        op(1, 0, exp_off(1), 4, 32'hFA, "R7");
        rd_cnt("R7");
        // R9 other addresses
        op(1, 0, exp_off(1) + 1, 1, 32'hFA, "R9");
        op(1, 0, exp_off(4), 1, 32'hFA, "R9");
        op(1, 0, 5, 1, 32'hFA, "R9");
        rd_cnt("R9");

        // R8 data-match on I/O kind 2
        op(1, 1, 0, 1, 2, "");
        op(1, 1, exp_off(5), 1, 32'hFA, "R8");
        op(1, 1, exp_off(5), 2, 32'hFA, "R8");
        op(1, 1, exp_off(5), 1, 32'hFB, "R8");
        op(1, 1, exp_off(5), 1, 32'h1FA, "R8");
        rd_cnt("R8");
        op(0, 1, 0, 1, 0, "R11");

        // R10 kind 0 counts without an event
        op(1, 1, 0, 1, 0, "");
        op(1, 1, exp_off(3), 1, 32'hFA, "R10");
        op(1, 1, exp_off(3), 1, 32'hFA, "R10");
        rd_cnt("R10");

        // R3 deselect with small and wide values, idle writes ignored
        op(1, 0, 0, 1, 3, "R3");
        op(0, 0, 0, 1, 0, "R3");
        op(1, 0, exp_off(3), 1, 32'hFA, "R3");
        op(1, 1, 0, 1, 32'h0001_0000, "R3");
        op(0, 0, 12, 1, 0, "R3");
        op(1, 1, 0, 1, 0, "R2");
        rd_cnt("R2");

        // R11 flag cleared by reselect, R1 reset deactivates
        op(1, 0, 0, 1, 2, "");
        op(1, 0, exp_off(2), 1, 32'hFA, "R11");
        op(1, 0, 0, 1, 2, "R11");
        op(1, 0, exp_off(2), 1, 32'hFA, "R11");
        do_reset();
        chk("R1", 32'(evt_flag), 0);
        op(0, 0, 0, 1, 0, "R1");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int r  = int'($urandom % 10);
            int s  = int'($urandom % 6);
            bit w  = 1'($urandom % 2);
            int sz = ($urandom % 4 == 0) ? 2 : 1;
            logic [31:0] d = ($urandom % 2 == 0) ? 32'hFA : $urandom;
            if (r == 0) begin
                op(1, w, 0, 1, ($urandom % 8 == 0) ? $urandom : 32'($urandom % 5), "");
            end else if (r <= 3) begin
                op(1, w, exp_off((m_active && $urandom % 2 == 0) ? m_slot : s), sz, d, "");
            end else if (r == 4) begin
                op(1, w, 1 + int'($urandom % 4095), sz, d, "R9");
            end else begin
                op(0, w, int'($urandom % 44), sz, 0, "");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule